// File: doc/BRIEF.md
# Paged Serial-Memory Write and Read Controller

This block sits behind a two-wire serial slave front end and in front of a byte-wide storage array, which is modelled inside the block as a register array. The front end decodes the bus and passes the block a set of single-cycle events: start, stop, a received slave-address byte, a received byte, a write-protect strobe and a request for the next byte to transmit. The block answers each address byte and each received byte with one acknowledge decision. It also keeps the address pointer and supplies read data.

Write data is collected in a page-sized staging buffer. Within the page only the low pointer bits advance. The buffered bytes are committed to storage in a single step when stop arrives, and this starts a timed write cycle. While that cycle runs, and while the power-up delay that follows reset runs, every slave address is refused. A host can therefore poll for completion. Reads walk the whole array and wrap from the top location to zero. The storage is erased to 8'hFF at reset.

Top module: `eep_page_ctl`

## Requirements
- R1: After reset every storage location reads 8'hFF and busy_o is low.
- R2: For PWRUP_CYCLES clocks after reset, every slave-address byte gets ack_valid_o=1 with ack_o=0. After that, a matching address gets ack_o=1.
- R3: A slave-address byte is `{4'b1010, sel[2:0], rw}`. The bits sel[2:ADDR_W-8] must equal the same bits of cs_pins_i, and the low ADDR_W-8 bits of sel are high memory-address bits. Any mismatch is answered with ack_o=0, and the received bytes of that frame are ignored and not answered.
- R4: In a write frame (rw=0), the first received byte is acknowledged and loads the pointer as `{sel[ADDR_W-9:0], byte}`.
- R5: Each later received byte is acknowledged and stored in the page buffer at the low PAGE_W pointer bits. Only those bits increment, and the page bits stay fixed.
- R6: When more than 2**PAGE_W data bytes arrive, the offset wraps to the start of the page and the later bytes replace the earlier ones.
- R7: A stop after at least one accepted data byte writes all buffered bytes into the page at once. Locations in the page that were not written keep their value.
- R8: A commit raises busy_o on the next clock for WR_CYCLES clocks. Slave addresses are refused during that time and acknowledged again once busy_o falls.
- R9: wp_i is latched at wp_strobe_i, before the first data byte. If it is high, that data byte is refused, the rest of the frame is ignored, nothing is written and busy_o stays low. If it is low, the write proceeds.
- R10: A read frame (rw=1) starts at the current pointer. A word address followed by a new start and a read address gives a random read from the loaded pointer.
- R11: Each tx_req_i in a read frame puts the byte at the pointer on tx_byte_o on the next clock and increments the pointer across the whole array, wrapping from the top location to 0.
- R12: A stop that comes before any data byte is accepted starts no write cycle and leaves busy_o low. A word address received in that frame is kept in the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; erases storage |
| start_i | input | 1 | Start or repeated-start event pulse |
| stop_i | input | 1 | Stop event pulse |
| dev_valid_i | input | 1 | Slave-address byte received |
| dev_byte_i | input | 8 | Slave-address byte `{1010, sel, rw}` |
| rx_valid_i | input | 1 | Byte received in write direction |
| rx_byte_i | input | 8 | Received byte |
| wp_strobe_i | input | 1 | Sampling instant for write protect |
| wp_i | input | 1 | Write-protect level (high blocks writes) |
| cs_pins_i | input | 3 | Chip-select strap levels |
| tx_req_i | input | 1 | Front end loads the next byte to send |
| tx_byte_o | output | 8 | Byte to transmit |
| ack_valid_o | output | 1 | Acknowledge decision valid (one cycle) |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| busy_o | output | 1 | Internal write cycle running |

## Verification
The assertions assume the front end never raises start_i, stop_i and a byte event in the same cycle. They also assume it sends wp_strobe_i strictly between the word-address byte and the first data byte. The bench pulses each event for exactly one clock with idle cycles between events and issues a strobe only in that gap. It also shortens the write cycle and power-up delay through parameters, so that busy windows can be observed from start to end.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_DEV, S_WORD, S_DATA, S_READ, S_SKIP
   } ctl_st_e;
   localparam logic [3:0] DEV_TYPE = 4'b1010;
   localparam logic [7:0] ERASED   = 8'hFF;
endpackage

// File: rtl/eep_timer.sv
module eep_timer #(
   parameter int CYCLES       = 16,
   parameter bit RUN_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic run_o
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("eep_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= RUN_AT_RESET ? LOAD : '0;
      else if (start_i)       cnt <= LOAD;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign run_o = (cnt != '0);

   // R8
   timer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> run_o);
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
   parameter int PAGE_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_i,
   input  logic                        wr_i,
   input  logic [PAGE_W-1:0]           off_i,
   input  logic [7:0]                  din_i,
   output logic [(1<<PAGE_W)-1:0][7:0] data_o,
   output logic [(1<<PAGE_W)-1:0]      mask_o
);
   localparam int PAGE_BYTES = 1 << PAGE_W;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o[g] <= '0;
            mask_o[g] <= 1'b0;
         end else if (clr_i) begin
            mask_o[g] <= 1'b0;
         end else if (wr_i && off_i == PAGE_W'(g)) begin
            data_o[g] <= din_i;
            mask_o[g] <= 1'b1;
         end
      end
   end

   // R7
   buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mask_o == '0));
endmodule

// File: rtl/eep_store.sv
module eep_store
   import eep_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int PAGE_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit_i,
   input  logic [ADDR_W-PAGE_W-1:0]    page_i,
   input  logic [(1<<PAGE_W)-1:0][7:0] pdata_i,
   input  logic [(1<<PAGE_W)-1:0]      pmask_i,
   input  logic [ADDR_W-1:0]           raddr_i,
   output logic [7:0]                  rdata_o
);
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= ERASED;
      end else if (commit_i) begin
         for (int i = 0; i < PAGE_BYTES; i++)
            if (pmask_i[i]) mem[{page_i, PAGE_W'(i)}] <= pdata_i[i];
      end
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/eep_page_ctl.sv
module eep_page_ctl
   import eep_pkg::*;
#(
   parameter int ADDR_W       = 9,
   parameter int PAGE_W       = 4,
   parameter int WR_CYCLES    = 250000,
   parameter int PWRUP_CYCLES = 50000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       dev_valid_i,
   input  logic [7:0] dev_byte_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_byte_i,
   input  logic       wp_strobe_i,
   input  logic       wp_i,
   input  logic [2:0] cs_pins_i,
   input  logic       tx_req_i,
   output logic [7:0] tx_byte_o,
   output logic       ack_valid_o,
   output logic       ack_o,
   output logic       busy_o
);
   localparam int HI_W = ADDR_W - 8;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam logic [2:0] PIN_MASK = 3'b111 << HI_W;
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr
      $error("eep_page_ctl: ADDR_W must be 9..11");
   end
   if (PAGE_W < 1 || PAGE_W > 7) begin : g_bad_page
      $error("eep_page_ctl: PAGE_W must be 1..7");
   end

   ctl_st_e st;
   logic [ADDR_W-1:0] ptr;
   logic [HI_W-1:0]   hi_r;
   logic              wp_lat, got_data;
   logic              pwr_run, addr_ok, ready, commit, buf_clr, buf_wr;
   logic [PAGE_BYTES-1:0][7:0] pdata;
   logic [PAGE_BYTES-1:0]      pmask;
   logic [7:0]        rdata;

   assign addr_ok = (dev_byte_i[7:4] == DEV_TYPE) &&
                    (((dev_byte_i[3:1] ^ cs_pins_i) & PIN_MASK) == 3'b000);
   assign ready   = !pwr_run && !busy_o;
   assign commit  = stop_i && !start_i && st == S_DATA && got_data;
   assign buf_clr = start_i || (st == S_WORD && rx_valid_i);
   assign buf_wr  = !start_i && !stop_i && st == S_DATA && rx_valid_i && !wp_lat;

   eep_timer #(.CYCLES(PWRUP_CYCLES), .RUN_AT_RESET(1'b1)) u_pwr (
      .clk(clk), .rst_n(rst_n), .start_i(1'b0), .run_o(pwr_run));

   eep_timer #(.CYCLES(WR_CYCLES), .RUN_AT_RESET(1'b0)) u_wr (
      .clk(clk), .rst_n(rst_n), .start_i(commit), .run_o(busy_o));

   eep_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr),
      .off_i(ptr[PAGE_W-1:0]), .din_i(rx_byte_i),
      .data_o(pdata), .mask_o(pmask));

   eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .commit_i(commit),
      .page_i(ptr[ADDR_W-1:PAGE_W]), .pdata_i(pdata), .pmask_i(pmask),
      .raddr_i(ptr), .rdata_o(rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         ptr         <= '0;
         hi_r        <= '0;
         wp_lat      <= 1'b0;
         got_data    <= 1'b0;
         ack_valid_o <= 1'b0;
         ack_o       <= 1'b0;
         tx_byte_o   <= '0;
      end else begin
         ack_valid_o <= 1'b0;
         if (start_i) begin
            st       <= S_DEV;
            wp_lat   <= 1'b0;
            got_data <= 1'b0;
         end else if (stop_i) begin
            st <= S_IDLE;
         end else begin
            unique case (st)
               S_DEV: if (dev_valid_i) begin
                  ack_valid_o <= 1'b1;
                  ack_o       <= addr_ok && ready;
                  if (addr_ok && ready) begin
                     hi_r <= dev_byte_i[HI_W:1];
                     st   <= dev_byte_i[0] ? S_READ : S_WORD;
                  end else begin
                     st <= S_SKIP;
                  end
               end
               S_WORD: if (rx_valid_i) begin
                  ptr         <= {hi_r, rx_byte_i};
                  ack_valid_o <= 1'b1;
                  ack_o       <= 1'b1;
                  st          <= S_DATA;
               end
               S_DATA: begin
                  if (wp_strobe_i && !got_data) wp_lat <= wp_i;
                  if (rx_valid_i) begin
                     ack_valid_o <= 1'b1;
                     ack_o       <= !wp_lat;
                     if (wp_lat) begin
                        st <= S_SKIP;
                     end else begin
                        got_data <= 1'b1;
                        ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                     end
                  end
               end
               S_READ: if (tx_req_i) begin
                  tx_byte_o <= rdata;
                  ptr       <= ptr + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R8
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid_i && st == S_DEV && !start_i && !stop_i && (busy_o || pwr_run))
      |=> (ack_valid_o && !ack_o));

   // R5
   page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DATA && rx_valid_i && !start_i && !stop_i)
      |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

   // R11
   read_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_READ && tx_req_i && !start_i && !stop_i && ptr == TOP_ADDR)
      |=> (ptr == '0));

   // R12
   no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !got_data && !busy_o) |=> !busy_o);
endmodule

// File: tb/eep_page_ctl_test.sv
module eep_page_ctl_test;
   localparam int WR  = 100;
   localparam int PWR = 30;
   localparam logic [2:0] PINS = 3'b010;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, stop_i = 0, dev_valid_i = 0, rx_valid_i = 0;
   logic wp_strobe_i = 0, wp_i = 0, tx_req_i = 0;
   logic [7:0] dev_byte_i = 0, rx_byte_i = 0, tx_byte_o;
   logic [2:0] cs_pins_i = PINS;
   logic ack_valid_o, ack_o, busy_o;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   eep_page_ctl #(.ADDR_W(9), .PAGE_W(4), .WR_CYCLES(WR), .PWRUP_CYCLES(PWR)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .dev_valid_i(dev_valid_i), .dev_byte_i(dev_byte_i),
      .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
      .wp_strobe_i(wp_strobe_i), .wp_i(wp_i), .cs_pins_i(cs_pins_i),
      .tx_req_i(tx_req_i), .tx_byte_o(tx_byte_o),
      .ack_valid_o(ack_valid_o), .ack_o(ack_o), .busy_o(busy_o));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_start();
      @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
   endtask
   task automatic do_stop();
      @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0;
   endtask
   task automatic send_dev(input logic [7:0] b, input logic exp, input string req);
      @(negedge clk) dev_valid_i = 1; dev_byte_i = b;
      @(negedge clk) dev_valid_i = 0;
      check(req, {6'd0, ack_valid_o, ack_o}, {6'd0, 1'b1, exp});
   endtask
   task automatic send_rx(input logic [7:0] b, input logic exp, input string req);
      @(negedge clk) rx_valid_i = 1; rx_byte_i = b;
      @(negedge clk) rx_valid_i = 0;
      check(req, {6'd0, ack_valid_o, ack_o}, {6'd0, 1'b1, exp});
   endtask
   task automatic read_byte(input logic [7:0] exp, input string req);
      @(negedge clk) tx_req_i = 1; @(negedge clk) tx_req_i = 0;
      check(req, tx_byte_o, exp);
   endtask
   task automatic strobe(input logic lvl);
      @(negedge clk) wp_strobe_i = 1; wp_i = lvl; @(negedge clk) wp_strobe_i = 0;
   endtask
   function automatic logic [7:0] dev(input logic a8, input logic rw);
      return {4'b1010, PINS[2:1], a8, rw};
   endfunction
   task automatic point(input logic a8, input logic [7:0] wa, input string req);
      do_start(); send_dev(dev(a8, 1'b0), 1'b1, req); send_rx(wa, 1'b1, req);
   endtask

   task automatic t_powerup();
      check("R1 busy after reset", {7'd0, busy_o}, 8'd0);
      do_start(); send_dev(dev(0, 0), 1'b0, "R2 nack in power-up"); do_stop();
      repeat (PWR + 5) @(negedge clk);
      do_start(); send_dev(dev(0, 0), 1'b1, "R2 ack after power-up"); do_stop();
   endtask

   task automatic t_erased();
      point(0, 8'h10, "R4 word address");
      do_start(); send_dev(dev(0, 1), 1'b1, "R10 read address");
      read_byte(8'hFF, "R1 erased 0x010");
      read_byte(8'hFF, "R1 erased 0x011");
      do_stop();
   endtask

   task automatic t_select();
      do_start(); send_dev({4'b1011, PINS[2:1], 1'b0, 1'b0}, 1'b0, "R3 bad type");
      @(negedge clk) rx_valid_i = 1; rx_byte_i = 8'h00;
      @(negedge clk) rx_valid_i = 0;
      check("R3 skipped byte unanswered", {7'd0, ack_valid_o}, 8'd0);
      do_stop();
      do_start(); send_dev({4'b1010, ~PINS[2:1], 1'b0, 1'b0}, 1'b0, "R3 bad pins");
      do_stop();
   endtask

   task automatic t_page_write();
      point(1, 8'h23, "R4 word address high page");
      send_rx(8'hA0, 1'b1, "R5 data ack");
      send_rx(8'hA1, 1'b1, "R5 data ack");
      send_rx(8'hA2, 1'b1, "R5 data ack");
      do_stop();
      check("R8 busy after commit", {7'd0, busy_o}, 8'd1);
      do_start(); send_dev(dev(1, 0), 1'b0, "R8 nack while busy"); do_stop();
      repeat (WR + 5) @(negedge clk);
      check("R8 busy falls", {7'd0, busy_o}, 8'd0);
      do_start(); send_dev(dev(1, 0), 1'b1, "R8 poll ack"); do_stop();
      point(1, 8'h22, "R10 random read setup");
      do_start(); send_dev(dev(1, 1), 1'b1, "R10 random read");
      read_byte(8'hFF, "R7 untouched 0x122");
      read_byte(8'hA0, "R7 0x123");
      read_byte(8'hA1, "R7 0x124");
      read_byte(8'hA2, "R7 0x125");
      read_byte(8'hFF, "R7 untouched 0x126");
      do_stop();
   endtask

   task automatic t_wrap();
      point(0, 8'h3E, "R4 word address 0x03E");
      for (int k = 0; k < 18; k++) send_rx(8'(8'h40 + k), 1'b1, "R6 data ack");
      do_stop();
      repeat (WR + 5) @(negedge clk);
      point(0, 8'h30, "R6 read setup");
      do_start(); send_dev(dev(0, 1), 1'b1, "R6 read");
      for (int j = 0; j < 16; j++) begin
         logic [7:0] e;
         e = (j < 14) ? 8'(8'h42 + j) : 8'(8'h50 + j - 14);
         read_byte(e, "R6 page wrap overwrite");
      end
      read_byte(8'hFF, "R5 next page untouched");
      do_stop();
   endtask

   task automatic t_protect();
      point(0, 8'h50, "R9 word address");
      strobe(1'b1);
      send_rx(8'h11, 1'b0, "R9 protected byte nack");
      @(negedge clk) rx_valid_i = 1; rx_byte_i = 8'h22;
      @(negedge clk) rx_valid_i = 0;
      check("R9 rest ignored", {7'd0, ack_valid_o}, 8'd0);
      do_stop();
      check("R9 no write cycle", {7'd0, busy_o}, 8'd0);
      point(0, 8'h50, "R9 readback setup");
      do_start(); send_dev(dev(0, 1), 1'b1, "R9 readback");
      read_byte(8'hFF, "R9 location unchanged");
      do_stop();
      point(0, 8'h00, "R9 unprotected write");
      strobe(1'b0);
      send_rx(8'h5A, 1'b1, "R9 unprotected byte ack");
      do_stop();
      check("R9 write cycle runs", {7'd0, busy_o}, 8'd1);
      repeat (WR + 5) @(negedge clk);
   endtask

   task automatic t_word_only();
      point(1, 8'hFF, "R12 word address 0x1FF");
      do_stop();
      check("R12 no busy", {7'd0, busy_o}, 8'd0);
      do_start(); send_dev(dev(0, 1), 1'b1, "R10 current read");
      read_byte(8'hFF, "R10 current address 0x1FF");
      read_byte(8'h5A, "R11 wrap to 0x000");
      read_byte(8'hFF, "R11 then 0x001");
      do_stop();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_powerup();
      t_erased();
      t_select();
      t_page_write();
      t_wrap();
      t_protect();
      t_word_only();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #4000000;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule